// File: doc/BRIEF.md
# Restoring Divider with Shared Remainder/Quotient Register

This block divides two 32-bit operands over several clock cycles using the restoring method. A single register of twice the operand width, plus one guard bit above it, carries the partial remainder in its upper half. The quotient grows bit by bit in its lower half as the register shifts left. One subtractor, one operand wide plus two bits, produces a trial difference on every step. When that difference goes negative, the old upper half is kept, which restores the partial remainder.

A caller drives the two operands and a signed/unsigned select, then pulses `start` for one cycle while the divider is idle. When the work is finished, the block pulses `done` for one cycle. The quotient (the low word) and the remainder (the high word) then hold steady until the next result. Signed operation converts both operands to magnitudes before the unsigned loop. On the way out it negates the quotient and the remainder as the operand signs require. A zero divisor skips the loop altogether and raises `div_zero` together with `done`.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `quotient` and `remainder` are 0, and `done` and `div_zero` are 0.
- R2: With `signed_mode`=0 and a nonzero divisor, `quotient` is the integer part of dividend/divisor and `remainder` is dividend mod divisor. Both are valid in the cycle in which `done` is 1, which is W+1 clock edges after the edge that accepted `start` (W=32).
- R3: With `signed_mode`=1, the operands are two's complement and the quotient rounds toward zero. The quotient is negative when the operand signs differ, and a nonzero remainder has the sign of the dividend. For example, -7/2 gives quotient -3 and remainder -1.
- R4: With `signed_mode`=1, dividing 0x80000000 by 0xFFFFFFFF (-1) gives quotient 0x80000000 and remainder 0.
- R5: A zero divisor sets `done`=1 and `div_zero`=1 in the cycle right after the accepting edge. `quotient` and `remainder` keep the values they held before.
- R6: `div_zero` stays 1 until the next accepted start. A division with a nonzero divisor ends with `div_zero`=0.
- R7: While a division is in progress, `start` and any change on the operand inputs have no effect. The result reflects the operands captured at the accepting edge, and no extra `done` pulse follows.
- R8: `done` is 1 for exactly one cycle per accepted start. `quotient` and `remainder` change only on a cycle in which `done` is 1.
- R9: A divisor larger than the dividend gives quotient 0 and remainder equal to the dividend. A divisor with its top bit set still gives the exact result: 0xFFFFFFFF/0x80000001 gives quotient 1 and remainder 0x7FFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division; accepted only while idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, captured on the accepting edge |
| divisor | input | 32 | Divisor, captured on the accepting edge |
| quotient | output | 32 | Quotient (low word of the result) |
| remainder | output | 32 | Remainder (high word of the result) |
| done | output | 1 | One-cycle pulse marking a new result |
| div_zero | output | 1 | Divisor was zero; valid with and after `done` |

## Verification
The hardest case to reach is a partial remainder that overflows the upper half after a shift. This happens only when the divisor's top bit is set and the running remainder is large. Uniform random operands rarely produce it, so the stimulus mixes in divisors with the top bit forced on, alongside directed cases such as 0xFFFFFFFF/0x80000001. A second hard case is a start pulse arriving in the middle of a run. The stimulus fires one a few cycles into a division, with different operands driven at the same time.

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done,
  output logic         div_zero
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t         state;
  logic [2*W:0]   acc;
  logic [W-1:0]   dvs;
  logic [CW-1:0]  cnt;
  logic           neg_q, neg_r;

  wire          a_neg = signed_mode & dividend[W-1];
  wire          b_neg = signed_mode & divisor[W-1];
  wire [W-1:0]  a_mag = a_neg ? -dividend : dividend;
  wire [W-1:0]  b_mag = b_neg ? -divisor : divisor;

  wire [W:0]    hi_ext = acc[2*W:W];
  wire [W+1:0]  diff   = {1'b0, hi_ext} - {2'b00, dvs};
  wire          fits   = ~diff[W+1] & ~diff[W];
  wire [W-1:0]  keep   = fits ? diff[W-1:0] : acc[2*W-1:W];

  wire [W-1:0]  q_mag = acc[W-1:0];
  wire [W-1:0]  r_mag = acc[2*W:W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      acc       <= '0;
      dvs       <= '0;
      cnt       <= '0;
      neg_q     <= 1'b0;
      neg_r     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (divisor == '0) begin
            done     <= 1'b1;
            div_zero <= 1'b1;
          end else begin
            div_zero <= 1'b0;
            acc      <= {{W{1'b0}}, a_mag, 1'b0};
            dvs      <= b_mag;
            neg_q    <= a_neg ^ b_neg;
            neg_r    <= a_neg;
            cnt      <= '0;
            state    <= S_RUN;
          end
        end
        S_RUN: begin
          acc <= {keep, acc[W-1:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) state <= S_FIN;
        end
        default: begin
          quotient  <= neg_q ? -q_mag : q_mag;
          remainder <= neg_r ? -r_mag : r_mag;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         signed_mode,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         done,
  input logic         div_zero
);
  logic         pend;
  logic [W-1:0] cap_a, cap_b;
  logic         cap_s;
  int           lat;

  wire accept = start && (!pend || done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      cap_a <= '0;
      cap_b <= '0;
      cap_s <= 1'b0;
      lat   <= 0;
    end else if (accept) begin
      pend  <= 1'b1;
      cap_a <= dividend;
      cap_b <= divisor;
      cap_s <= signed_mode;
      lat   <= 0;
    end else begin
      if (done) pend <= 1'b0;
      if (pend) lat <= lat + 1;
    end
  end

  wire [2*W-1:0] recomb = {{W{1'b0}}, quotient} * {{W{1'b0}}, cap_b} + {{W{1'b0}}, remainder};

  AST_UNSIGNED_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done && !div_zero && !cap_s |-> recomb == {{W{1'b0}}, cap_a} && remainder < cap_b); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat == (div_zero ? 0 : W + 1)); // R2
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    done && !div_zero && cap_s && remainder != '0 |-> remainder[W-1] == cap_a[W-1]); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> div_zero == (cap_b == '0)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient) && $stable(remainder)); // R8
endmodule

bind restoring_divider restoring_divider_chk #(.W(W)) chk_i (.*);

// File: tb/restoring_divider_tb_top.sv
module restoring_divider_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient, remainder;
  logic         done, div_zero;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  restoring_divider #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .quotient(quotient),
    .remainder(remainder), .done(done), .div_zero(div_zero)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    logic an, bn;
    logic [W-1:0] ma, mb, mq, mr;
    an = s && a[W-1];
    bn = s && b[W-1];
    ma = an ? (~a + 1'b1) : a;
    mb = bn ? (~b + 1'b1) : b;
    mq = ma / mb;
    mr = ma % mb;
    q = (an != bn) ? (~mq + 1'b1) : mq;
    r = an ? (~mr + 1'b1) : mr;
  endfunction

  int lat;

  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    @(negedge clk);
    dividend = a; divisor = b; signed_mode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 500) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input string req);
    logic [W-1:0] eq, er;
    model(a, b, s, eq, er);
    launch(a, b, s);
    check({req, " latency"}, W'(lat), W'(W + 1));
    check({req, " quotient"}, quotient, eq);
    check({req, " remainder"}, remainder, er);
    check({req, " R6 div_zero low"}, W'(div_zero), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] q0, r0, a, b;
    int extra;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check("R1 quotient", quotient, '0);
    check("R1 remainder", remainder, '0);
    check("R1 done", W'(done), '0);
    check("R1 div_zero", W'(div_zero), '0);
    rst_n = 1'b1;

    run(32'd7, 32'd2, 1'b0, "R2 7/2");
    run(32'd1000, 32'd10, 1'b0, "R2 exact");
    run(32'hFFFFFFFF, 32'd1, 1'b0, "R2 max/1");
    run(32'd5, 32'd9, 1'b0, "R9 small dividend");
    run(32'hFFFFFFFF, 32'h80000001, 1'b0, "R9 top-bit divisor");
    run(32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0, "R9 near max");
    run(-32'sd7, 32'd2, 1'b1, "R3 -7/2");
    run(32'd7, -32'sd2, 1'b1, "R3 7/-2");
    run(-32'sd7, -32'sd2, 1'b1, "R3 -7/-2");
    run(32'h80000000, 32'hFFFFFFFF, 1'b1, "R4 overflow");

    q0 = quotient; r0 = remainder;
    launch(32'd123, 32'd0, 1'b0);
    check("R5 latency", W'(lat), '0);
    check("R5 div_zero", W'(div_zero), W'(1));
    check("R5 quotient held", quotient, q0);
    check("R5 remainder held", remainder, r0);
    repeat (4) @(negedge clk);
    check("R6 div_zero held", W'(div_zero), W'(1));
    run(32'd50, 32'd6, 1'b0, "R6 cleared");

    @(negedge clk);
    dividend = 32'd100; divisor = 32'd7; signed_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    dividend = 32'hFFFF; divisor = 32'd3; signed_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    check("R7 quotient", quotient, 32'd14);
    check("R7 remainder", remainder, 32'd2);
    q0 = quotient; r0 = remainder;
    extra = 0;
    for (int i = 0; i < W + 5; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R7 no extra done", W'(extra), '0);
    check("R8 quotient stable", quotient, q0);
    check("R8 remainder stable", remainder, r0);

    for (int i = 0; i < 400; i++) begin
      a = $urandom;
      b = $urandom;
      case (i % 4)
        0: b = b >> ($urandom % W);
        1: b = b | 32'h80000000;
        2: b = b & 32'hFF;
        default: ;
      endcase
      if (b == '0) b = 32'd1;
      run(a, b, 1'(i % 2), (i % 2) ? "R3 random" : "R2 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule